// File: doc/BRIEF.md
# Burst Write Segmenting Bridge

This block sits between the target side of a parallel bus and a memory-mapped write port. A write burst that the target has claimed arrives as a series of 32-bit data phases. The first phase carries a start strobe, a region-hit index, a byte address and a wrap-order flag. The last phase carries a last flag. Each phase is written into an internal data buffer. At each segment boundary a descriptor (region, segment address, beat count) is written into a descriptor buffer.

The data buffer keeps a commit pointer apart from its write pointer. Phases stay invisible downstream until their segment is committed. A segment is committed when the burst reaches the last word below a 32-byte address boundary, or when the burst ends, whichever comes first. The drain side issues each committed segment as one memory-mapped burst write. The address and burst count are presented with the first beat and held through the last. Byte enables pass through untouched.

A burst marked for cacheline-wrap order gets a disconnect request on its first phase, and only that phase is forwarded. Plain and invalidating memory writes are handled the same way, so the block has no command-type input. When either buffer is full, the block raises a wait signal toward the target side and never drops a phase.

Ingress states:
- `ING_IDLE`: waiting for a start phase. It stays here on a single-phase or wrap-ordered start, and on a phase that has no start strobe.
- `ING_BURST`: entered from `ING_IDLE` on an accepted multi-phase start. It returns to `ING_IDLE` on an accepted phase with the last flag set.

Drain states:
- `EG_IDLE`: waiting for a descriptor. It moves to `EG_SEND` when one is committed, loading the descriptor.
- `EG_SEND`: driving beats. It returns to `EG_IDLE` when the final beat is accepted with waitrequest low.

Top module: `wr_segment_bridge`

## Requirements
- R1: After reset, `mm_write`, `in_wait` and `in_disc` are all low.
- R2: A single-phase burst (start and last together, word-aligned byte address, low two bits zero) produces one downstream write with burst count 1 at that address.
- R3: A burst starting on a 32-byte boundary is issued as downstream bursts of 8 beats, each at the previous address plus 32. Only the final burst may be shorter, and no downstream burst crosses a 32-byte boundary.
- R4: A burst starting mid-block gets a first downstream burst that runs only up to the next 32-byte boundary. The count is 8 minus bits [4:2] of the start address. The last burst ends where the incoming burst ends.
- R5: Each downstream beat carries the data and the 4-bit byte enables of the matching incoming phase, in arrival order, unchanged, including the all-zero and partial patterns.
- R6: No beat of a segment appears downstream before the segment is committed. An unfinished burst that has not reached a boundary produces no downstream write.
- R7: When the wrap flag is set on a start phase, `in_disc` is high in the cycle that phase is accepted. Exactly one beat (burst count 1) is forwarded. Later phases without a start strobe are discarded.
- R8: When the buffer is full, `in_wait` is high and no phase is accepted. Every phase offered is later delivered once waitrequest is released.
- R9: While `mm_write` and `mm_waitrequest` are both high, address, burst count, data, byte enables and region are held unchanged into the next cycle.
- R10: Every downstream burst carries on `mm_region` the region-hit index given with the start of its incoming burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Data phase present |
| in_start | input | 1 | First phase of a burst; qualifies the region, address and wrap inputs |
| in_region | input | REG_W | Region-hit index of the burst |
| in_addr | input | ADDR_W | Byte address offset of the first phase (word aligned) |
| in_wrap | input | 1 | Burst uses cacheline-wrap ordering |
| in_data | input | 32 | Write data of the phase |
| in_be | input | 4 | Byte enables of the phase |
| in_last | input | 1 | Final phase of the burst |
| in_wait | output | 1 | Buffer full; the phase is not taken this cycle |
| in_disc | output | 1 | Disconnect request toward the target side |
| mm_write | output | 1 | Downstream write beat valid |
| mm_address | output | ADDR_W | Byte address of the current downstream burst |
| mm_burstcount | output | SEG_LG+1 | Beats in the current downstream burst |
| mm_writedata | output | 32 | Beat data |
| mm_byteenable | output | 4 | Beat byte enables |
| mm_region | output | REG_W | Region-hit index of the current burst |
| mm_waitrequest | input | 1 | Downstream stall |

## Verification
Bursts are tried from several starting points:
- An aligned start with a length that is not a multiple of 8 shows whether cuts fall on boundaries and how the tail is handled.
- A mid-block start shows whether the short first segment is sized from the address.
- A single phase isolates the commit-on-end path.

A burst left unfinished and then completed shows that nothing leaks out before commit. A wrap-ordered start followed by stray phases shows the disconnect and the one-beat limit. A permanently stalled downstream fills the buffer to expose the wait signal. Random waitrequest exposes whether outputs drift during a stall.

// File: rtl/wsb_pkg.sv
package wsb_pkg;

    typedef enum logic {
        ING_IDLE,
        ING_BURST
    } ing_state_t;

    typedef enum logic {
        EG_IDLE,
        EG_SEND
    } eg_state_t;

endpackage

// File: rtl/wsb_commit_fifo.sv
// Synchronous FIFO whose read side sees only entries below a commit pointer.
module wsb_commit_fifo #(
    parameter int W     = 36,
    parameter int DEPTH = 16   // power of two
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         commit,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         avail,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, cm_ptr, rd_ptr;
    logic [PW-1:0] wr_next;

    assign wr_next = push ? wr_ptr + PW'(1) : wr_ptr;
    assign full    = (wr_ptr - rd_ptr) == PW'(DEPTH);
    assign avail   = cm_ptr != rd_ptr;
    assign rdata   = mem[rd_ptr[AW-1:0]];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            cm_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            wr_ptr <= wr_next;
            if (commit) cm_ptr <= wr_next;
            if (pop)    rd_ptr <= rd_ptr + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr[AW-1:0]] <= wdata;
    end

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && full));

    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> avail);

endmodule

// File: rtl/wsb_ingress.sv
// Accepts target-side phases, tracks the open segment, commits at boundaries.
module wsb_ingress
    import wsb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int REG_W  = 3,
    parameter int SEG_LG = 3,
    localparam int WA_W   = ADDR_W - 2,
    localparam int CNT_W  = SEG_LG + 1,
    localparam int DESC_W = REG_W + WA_W + CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_start,
    input  logic [REG_W-1:0]  in_region,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_wrap,
    input  logic [31:0]       in_data,
    input  logic [3:0]        in_be,
    input  logic              in_last,
    output logic              in_wait,
    output logic              in_disc,
    input  logic              data_full,
    input  logic              desc_full,
    output logic              data_push,
    output logic [35:0]       data_wdata,
    output logic              commit,
    output logic              desc_push,
    output logic [DESC_W-1:0] desc_wdata
);
    localparam int SEG_WORDS = 1 << SEG_LG;

    ing_state_t        st_q, st_d;
    logic [WA_W-1:0]   cur_word_q, seg_word_q;
    logic [CNT_W-1:0]  beats_q;
    logic [REG_W-1:0]  seg_reg_q;

    logic              is_first, accept, wrap_now, hit_boundary, commit_now;
    logic [WA_W-1:0]   this_word, seg_base;
    logic [CNT_W-1:0]  prior;
    logic [REG_W-1:0]  reg_eff;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= ING_IDLE;
            cur_word_q <= '0;
            seg_word_q <= '0;
            beats_q    <= '0;
            seg_reg_q  <= '0;
        end else begin
            st_q <= st_d;
            if (accept) begin
                cur_word_q <= this_word + WA_W'(1);
                seg_word_q <= commit_now ? this_word + WA_W'(1) : seg_base;
                beats_q    <= commit_now ? '0 : prior + CNT_W'(1);
                seg_reg_q  <= reg_eff;
            end
        end
    end

    // Next state and outputs
    always_comb begin
        in_wait      = data_full || desc_full;
        is_first     = (st_q == ING_IDLE) && in_start;
        accept       = in_valid && !in_wait && ((st_q == ING_BURST) || in_start);
        this_word    = is_first ? in_addr[ADDR_W-1:2] : cur_word_q;
        prior        = is_first ? '0 : beats_q;
        seg_base     = is_first ? this_word : seg_word_q;
        reg_eff      = is_first ? in_region : seg_reg_q;
        hit_boundary = &this_word[SEG_LG-1:0];
        wrap_now     = is_first && in_wrap;
        commit_now   = accept && (in_last || wrap_now || hit_boundary);

        in_disc      = accept && wrap_now;
        data_push    = accept;
        data_wdata   = {in_be, in_data};
        commit       = commit_now;
        desc_push    = commit_now;
        desc_wdata   = {reg_eff, seg_base, prior + CNT_W'(1)};

        st_d = st_q;
        unique case (st_q)
            ING_IDLE:  if (accept && !(in_last || wrap_now)) st_d = ING_BURST;
            ING_BURST: if (accept && in_last)                st_d = ING_IDLE;
            default:   st_d = ING_IDLE;
        endcase
    end

    // R2
    aligned_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_first) |-> (in_addr[1:0] == 2'b00));

    // R7
    wrap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_disc |=> (st_q == ING_IDLE && beats_q == '0));

    // R6
    last_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_last) |=> (st_q == ING_IDLE && beats_q == '0));

    // R4
    seg_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desc_push |-> (int'(desc_wdata[CNT_W +: SEG_LG]) + int'(desc_wdata[CNT_W-1:0]) <= SEG_WORDS));

endmodule

// File: rtl/wsb_egress.sv
// Drains committed segments as memory-mapped burst writes.
module wsb_egress
    import wsb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int REG_W  = 3,
    parameter int SEG_LG = 3,
    localparam int WA_W   = ADDR_W - 2,
    localparam int CNT_W  = SEG_LG + 1,
    localparam int DESC_W = REG_W + WA_W + CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_avail,
    input  logic [DESC_W-1:0] desc_rdata,
    output logic              desc_pop,
    input  logic              data_avail,
    input  logic [35:0]       data_rdata,
    output logic              data_pop,
    output logic              mm_write,
    output logic [ADDR_W-1:0] mm_address,
    output logic [CNT_W-1:0]  mm_burstcount,
    output logic [31:0]       mm_writedata,
    output logic [3:0]        mm_byteenable,
    output logic [REG_W-1:0]  mm_region,
    input  logic              mm_waitrequest
);
    localparam int SEG_WORDS = 1 << SEG_LG;

    eg_state_t        st_q, st_d;
    logic [REG_W-1:0] reg_q;
    logic [WA_W-1:0]  word_q;
    logic [CNT_W-1:0] cnt_q, remain_q;
    logic             last_beat;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= EG_IDLE;
            reg_q    <= '0;
            word_q   <= '0;
            cnt_q    <= '0;
            remain_q <= '0;
        end else begin
            st_q <= st_d;
            if (desc_pop) begin
                reg_q    <= desc_rdata[DESC_W-1 -: REG_W];
                word_q   <= desc_rdata[CNT_W +: WA_W];
                cnt_q    <= desc_rdata[CNT_W-1:0];
                remain_q <= desc_rdata[CNT_W-1:0];
            end else if (data_pop) begin
                remain_q <= remain_q - CNT_W'(1);
            end
        end
    end

    // Next state and outputs
    always_comb begin
        desc_pop      = (st_q == EG_IDLE) && desc_avail;
        mm_write      = (st_q == EG_SEND);
        data_pop      = mm_write && !mm_waitrequest;
        last_beat     = remain_q == CNT_W'(1);
        mm_address    = {word_q, 2'b00};
        mm_burstcount = cnt_q;
        mm_region     = reg_q;
        mm_writedata  = data_rdata[31:0];
        mm_byteenable = data_rdata[35:32];

        st_d = st_q;
        unique case (st_q)
            EG_IDLE: if (desc_avail)            st_d = EG_SEND;
            EG_SEND: if (data_pop && last_beat) st_d = EG_IDLE;
            default: st_d = EG_IDLE;
        endcase
    end

    // R6
    beat_committed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mm_write |-> data_avail);

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_write && mm_waitrequest) |=> (mm_write && $stable(mm_address) &&
            $stable(mm_burstcount) && $stable(mm_writedata) &&
            $stable(mm_byteenable) && $stable(mm_region)));

    // R3
    no_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mm_write |-> (mm_burstcount != '0 &&
            int'(mm_address[SEG_LG+1:2]) + int'(mm_burstcount) <= SEG_WORDS));

endmodule

// File: rtl/wr_segment_bridge.sv
module wr_segment_bridge #(
    parameter int ADDR_W    = 16,
    parameter int REG_W     = 3,
    parameter int SEG_BYTES = 32,
    parameter int DEPTH     = 16,
    localparam int SEG_LG   = $clog2(SEG_BYTES / 4),
    localparam int CNT_W    = SEG_LG + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_start,
    input  logic [REG_W-1:0]  in_region,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_wrap,
    input  logic [31:0]       in_data,
    input  logic [3:0]        in_be,
    input  logic              in_last,
    output logic              in_wait,
    output logic              in_disc,
    output logic              mm_write,
    output logic [ADDR_W-1:0] mm_address,
    output logic [CNT_W-1:0]  mm_burstcount,
    output logic [31:0]       mm_writedata,
    output logic [3:0]        mm_byteenable,
    output logic [REG_W-1:0]  mm_region,
    input  logic              mm_waitrequest
);
    localparam int WA_W   = ADDR_W - 2;
    localparam int DESC_W = REG_W + WA_W + CNT_W;

    logic              data_push, data_commit, data_pop, data_avail, data_full;
    logic [35:0]       data_wdata, data_rdata;
    logic              desc_push, desc_pop, desc_avail, desc_full;
    logic [DESC_W-1:0] desc_wdata, desc_rdata;

    wsb_ingress #(.ADDR_W(ADDR_W), .REG_W(REG_W), .SEG_LG(SEG_LG)) u_ingress (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_start(in_start), .in_region(in_region),
        .in_addr(in_addr), .in_wrap(in_wrap), .in_data(in_data),
        .in_be(in_be), .in_last(in_last), .in_wait(in_wait), .in_disc(in_disc),
        .data_full(data_full), .desc_full(desc_full),
        .data_push(data_push), .data_wdata(data_wdata), .commit(data_commit),
        .desc_push(desc_push), .desc_wdata(desc_wdata)
    );

    wsb_commit_fifo #(.W(36), .DEPTH(DEPTH)) u_data_buf (
        .clk(clk), .rst_n(rst_n),
        .push(data_push), .wdata(data_wdata), .commit(data_commit),
        .pop(data_pop), .rdata(data_rdata), .avail(data_avail), .full(data_full)
    );

    wsb_commit_fifo #(.W(DESC_W), .DEPTH(DEPTH)) u_desc_buf (
        .clk(clk), .rst_n(rst_n),
        .push(desc_push), .wdata(desc_wdata), .commit(desc_push),
        .pop(desc_pop), .rdata(desc_rdata), .avail(desc_avail), .full(desc_full)
    );

    wsb_egress #(.ADDR_W(ADDR_W), .REG_W(REG_W), .SEG_LG(SEG_LG)) u_egress (
        .clk(clk), .rst_n(rst_n),
        .desc_avail(desc_avail), .desc_rdata(desc_rdata), .desc_pop(desc_pop),
        .data_avail(data_avail), .data_rdata(data_rdata), .data_pop(data_pop),
        .mm_write(mm_write), .mm_address(mm_address), .mm_burstcount(mm_burstcount),
        .mm_writedata(mm_writedata), .mm_byteenable(mm_byteenable),
        .mm_region(mm_region), .mm_waitrequest(mm_waitrequest)
    );

endmodule

// File: tb/test_wr_segment_bridge.sv
module test_wr_segment_bridge;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_start, in_wrap, in_last;
    logic [2:0]  in_region;
    logic [15:0] in_addr;
    logic [31:0] in_data;
    logic [3:0]  in_be;
    logic        in_wait, in_disc;
    logic        mm_write;
    logic [15:0] mm_address;
    logic [3:0]  mm_burstcount;
    logic [31:0] mm_writedata;
    logic [3:0]  mm_byteenable;
    logic [2:0]  mm_region;
    logic        mm_waitrequest;

    always #10 clk = ~clk;  // 50 MHz

    wr_segment_bridge i_wr_segment_bridge (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_start(in_start), .in_region(in_region),
        .in_addr(in_addr), .in_wrap(in_wrap), .in_data(in_data), .in_be(in_be),
        .in_last(in_last), .in_wait(in_wait), .in_disc(in_disc),
        .mm_write(mm_write), .mm_address(mm_address), .mm_burstcount(mm_burstcount),
        .mm_writedata(mm_writedata), .mm_byteenable(mm_byteenable),
        .mm_region(mm_region), .mm_waitrequest(mm_waitrequest)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Waitrequest generator
    bit         wr_mode = 1'b0;
    bit         wr_hold = 1'b0;
    logic [7:0] lfsr = 8'hA5;
    initial begin
        mm_waitrequest = 1'b0;
        forever begin
            @(posedge clk); #1;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            mm_waitrequest = wr_mode ? lfsr[0] : wr_hold;
        end
    end

    // Downstream monitor
    logic [15:0] rec_addr  [0:255];
    logic [3:0]  rec_cnt   [0:255];
    logic [31:0] rec_data  [0:255];
    logic [3:0]  rec_be    [0:255];
    logic [2:0]  rec_reg   [0:255];
    int          rec_total = 0;
    int          stall_seen = 0;
    bit          prev_stall = 1'b0;
    logic [15:0] p_addr;
    logic [3:0]  p_cnt, p_be;
    logic [31:0] p_data;
    logic [2:0]  p_reg;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall) begin
                // R9: outputs held across a stall
                chk(mm_write && mm_address == p_addr && mm_burstcount == p_cnt &&
                    mm_writedata == p_data && mm_byteenable == p_be && mm_region == p_reg,
                    "R9", "held outputs", longint'(mm_writedata), longint'(p_data));
            end
            prev_stall = mm_write && mm_waitrequest;
            if (prev_stall) stall_seen++;
            p_addr = mm_address; p_cnt = mm_burstcount; p_data = mm_writedata;
            p_be = mm_byteenable; p_reg = mm_region;
            if (mm_write && !mm_waitrequest && rec_total < 256) begin
                rec_addr[rec_total] = mm_address;
                rec_cnt[rec_total]  = mm_burstcount;
                rec_data[rec_total] = mm_writedata;
                rec_be[rec_total]   = mm_byteenable;
                rec_reg[rec_total]  = mm_region;
                rec_total++;
            end
        end
    end

    int base = 0;

    task automatic idle_inputs();
        in_valid = 1'b0; in_start = 1'b0; in_wrap = 1'b0; in_last = 1'b0;
        in_region = '0; in_addr = '0; in_data = '0; in_be = '0;
    endtask

    task automatic send_burst(input logic [2:0] rg, input logic [15:0] addr, input int n,
                              input bit wrap, input logic [31:0] dbase,
                              input logic [3:0] beseed, input bit first, input bit end_last);
        for (int i = 0; i < n; i++) begin
            in_valid  = 1'b1;
            in_start  = first && (i == 0);
            in_region = rg;
            in_addr   = addr;
            in_wrap   = wrap;
            in_data   = dbase + 32'(i);
            in_be     = beseed + 4'(i);
            in_last   = end_last && (i == n - 1);
            forever begin
                @(negedge clk);
                if (!in_wait) break;
            end
            if (first && i == 0)
                chk(in_disc == wrap, "R7", "disconnect on first phase",
                    longint'(in_disc), longint'(wrap));
            @(posedge clk); #1;
            idle_inputs();
        end
    endtask

    task automatic drain();
        repeat (120) @(posedge clk);
        #1;
    endtask

    task automatic expect_beats(input string req, input logic [2:0] rg, input logic [15:0] addr,
                                input int n, input logic [31:0] dbase, input logic [3:0] beseed);
        int w0;
        int seg;
        int cnt;
        w0 = int'(addr) >> 2;
        seg = 0;
        cnt = 0;
        chk(rec_total - base == n, req, "beat count", longint'(rec_total - base), longint'(n));
        for (int i = 0; i < n && i < rec_total - base; i++) begin
            int w;
            int k;
            w = w0 + i;
            k = base + i;
            if (i == 0 || (w % 8) == 0) begin
                seg = w;
                cnt = 8 - (w % 8);
                if (cnt > n - i) cnt = n - i;
            end
            chk(rec_addr[k] == 16'(seg * 4) && rec_cnt[k] == 4'(cnt), req, "address/burstcount",
                longint'({rec_addr[k], rec_cnt[k]}), longint'({16'(seg * 4), 4'(cnt)}));
            // R5: data and byte enables unchanged
            chk(rec_data[k] == dbase + 32'(i) && rec_be[k] == beseed + 4'(i), "R5", "data/byteenable",
                longint'({rec_be[k], rec_data[k]}), longint'({beseed + 4'(i), dbase + 32'(i)}));
            // R10: region forwarded
            chk(rec_reg[k] == rg, "R10", "region", longint'(rec_reg[k]), longint'(rg));
        end
        base = rec_total;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!mm_write && !in_wait && !in_disc, "R1", "reset outputs",
            longint'({mm_write, in_wait, in_disc}), 0);
    endtask

    task automatic t_single();
        send_burst(3'd2, 16'h0040, 1, 1'b0, 32'h1000_0000, 4'hF, 1'b1, 1'b1);
        drain();
        expect_beats("R2", 3'd2, 16'h0040, 1, 32'h1000_0000, 4'hF);
    endtask

    task automatic t_aligned();
        send_burst(3'd1, 16'h0100, 20, 1'b0, 32'h2000_0000, 4'h3, 1'b1, 1'b1);
        drain();
        expect_beats("R3", 3'd1, 16'h0100, 20, 32'h2000_0000, 4'h3);
        send_burst(3'd6, 16'h01E0, 8, 1'b0, 32'h2100_0000, 4'h8, 1'b1, 1'b1);
        drain();
        expect_beats("R3", 3'd6, 16'h01E0, 8, 32'h2100_0000, 4'h8);
    endtask

    task automatic t_unaligned();
        send_burst(3'd5, 16'h0214, 13, 1'b0, 32'h3000_0000, 4'h7, 1'b1, 1'b1);
        drain();
        expect_beats("R4", 3'd5, 16'h0214, 13, 32'h3000_0000, 4'h7);
    endtask

    task automatic t_byteen();
        // seed 0 makes the first beat all-disabled, later ones partial
        send_burst(3'd0, 16'h0308, 6, 1'b0, 32'h4000_0000, 4'h0, 1'b1, 1'b1);
        drain();
        expect_beats("R5", 3'd0, 16'h0308, 6, 32'h4000_0000, 4'h0);
    endtask

    task automatic t_commit();
        send_burst(3'd4, 16'h0400, 3, 1'b0, 32'h5000_0000, 4'h1, 1'b1, 1'b0);
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk(rec_total == base && !mm_write, "R6", "nothing visible before commit",
            longint'(rec_total - base), 0);
        send_burst(3'd4, 16'h0400, 1, 1'b0, 32'h5000_0003, 4'h4, 1'b0, 1'b1);
        drain();
        expect_beats("R6", 3'd4, 16'h0400, 4, 32'h5000_0000, 4'h1);
    endtask

    task automatic t_wrap();
        send_burst(3'd1, 16'h00A8, 4, 1'b1, 32'h6000_0000, 4'hF, 1'b1, 1'b1);
        drain();
        expect_beats("R7", 3'd1, 16'h00A8, 1, 32'h6000_0000, 4'hF);
    endtask

    task automatic t_full();
        wr_hold = 1'b1;
        fork
            send_burst(3'd3, 16'h0600, 20, 1'b0, 32'h7000_0000, 4'h2, 1'b1, 1'b1);
            begin
                repeat (30) @(negedge clk);
                chk(in_wait == 1'b1, "R8", "wait when buffer full", longint'(in_wait), 1);
                chk(rec_total == base, "R8", "no beat during stall", longint'(rec_total - base), 0);
                wr_hold = 1'b0;
            end
        join
        drain();
        expect_beats("R8", 3'd3, 16'h0600, 20, 32'h7000_0000, 4'h2);
    endtask

    task automatic t_stall();
        int s0;
        s0 = stall_seen;
        wr_mode = 1'b1;
        send_burst(3'd7, 16'h0734, 13, 1'b0, 32'h8000_0000, 4'h9, 1'b1, 1'b1);
        drain();
        wr_mode = 1'b0;
        drain();
        expect_beats("R9", 3'd7, 16'h0734, 13, 32'h8000_0000, 4'h9);
        chk(stall_seen > s0, "R9", "stall cycles occurred", longint'(stall_seen - s0), 1);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        @(posedge clk); #1;
        t_single();
        t_aligned();
        t_unaligned();
        t_byteen();
        t_commit();
        t_wrap();
        t_full();
        t_stall();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule